// File: doc/BRIEF.md
# Presettable Up/Down Decade or Binary Counter Stage

This block is a 4-bit synchronous counter that counts up or down on the rising clock edge. A single parameter sets the modulus: decade mode counts through the codes 0 to 9, and binary mode uses all sixteen codes. The counter has two level-sensitive overrides. The first is a clear input. The second is a load input that places a 4-bit value on the count. The clear wins whenever both are high.

Counting is enabled by an active-low carry input. The stage produces an active-low carry output, which goes low only at the terminal code for the current direction. Several stages can share one clock if each stage's carry output drives the carry input of the next, more significant stage. The result is a multi-digit synchronous counter. In decade mode, if the register is loaded with an unused code (10 to 15), it returns to a legal digit within a bounded number of counting clocks.

Top module: `ud_count_stage`

## Requirements
- R1: While `resetIn` is high, `countOut` is 0 at once, with no clock edge needed, whatever the levels on `loadEn`, `cinN` and `countUp`.
- R2: While `resetIn` is low and `loadEn` is high, `countOut` equals `loadVal` at once, whatever `cinN` and `countUp` are. A rising edge in that state stores the value, so it remains after `loadEn` falls.
- R3: With `resetIn` and `loadEn` low and `cinN` high, `countOut` is unchanged across every rising edge.
- R4: With `resetIn`, `loadEn` and `cinN` low, each rising edge adds one to `countOut` when `countUp` is 1 and subtracts one when `countUp` is 0.
- R5: In decade mode, counting up from 9 gives 0 and counting down from 0 gives 9, and a legal code only ever leads to another legal code. In binary mode, 15 up gives 0 and 0 down gives 15.
- R6: `coutN` is low exactly when `cinN` is low and `countOut` is at the terminal code for the current direction. The terminal code counting up is 9 in decade mode and 15 in binary mode. The terminal code counting down is 0 in both modes.
- R7: A high `cinN` forces `coutN` high in the same cycle. Three decade stages on one clock, each `coutN` wired to the next `cinN`, form a counter from 0 to 999 that wraps in both directions.
- R8: In decade mode, a counting edge from an unused code behaves as follows. Counting up, the odd codes 11, 13 and 15 go to 0 and the even codes 10, 12 and 14 go to the next code. Counting down, any unused code goes to the code minus two. A legal code is therefore reached within 2 up-counting edges or 4 down-counting edges.
- R9: The first rising edge after `resetIn` falls does not count, even if `cinN` is low. Counting resumes on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| resetIn | input | 1 | Level-sensitive clear, highest priority |
| loadEn | input | 1 | Level-sensitive load of `loadVal` |
| loadVal | input | 4 | Value placed on the count during load |
| cinN | input | 1 | Active-low count enable and carry input |
| countUp | input | 1 | 1 counts up, 0 counts down |
| countOut | output | 4 | Current count |
| coutN | output | 1 | Active-low carry output to the next stage |

## Verification
The assertions assume that every load pulse spans at least one rising edge, because a load pulse with no edge in it is shown on the output but never stored. They also assume that inputs change away from the rising edge. The bench meets both assumptions by driving every input on the falling edge and holding each load for at least one full cycle. The step and recovery properties only apply to edges where the control block issues a counting strobe. The stimulus therefore keeps a reset release followed by counting, and loads of the unused codes followed by counting in both directions, so that these properties are actually exercised.

// File: rtl/udc_pkg.sv
package udc_pkg;
  // Strobes from the control block to the datapath.
  typedef struct packed {
    logic clear;  // asynchronous clear of the count register
    logic load;   // show and capture the load value
    logic step;   // advance one code on this edge
    logic dirUp;  // direction for the step
  } ctl_t;
endpackage

// File: rtl/udc_ctrl.sv
module udc_ctrl
  import udc_pkg::*;
(
  input  logic clk,
  input  logic resetIn,
  input  logic loadEn,
  input  logic cinN,
  input  logic countUp,
  output ctl_t ctl
);
  // Held high by reset and cleared on the first edge after release, so that edge never counts.
  logic rstHold;

  always_ff @(posedge clk or posedge resetIn) begin
    if (resetIn) rstHold <= 1'b1;
    else         rstHold <= 1'b0;
  end

  // Fixed priority: clear, then load, then count.
  always_comb begin
    ctl.clear = resetIn;
    ctl.load  = !resetIn && loadEn;
    ctl.step  = !resetIn && !loadEn && !cinN && !rstHold;
    ctl.dirUp = countUp;
  end

  AST_NO_STEP_AFTER_RELEASE: assert property (@(posedge clk) disable iff (resetIn)
    $fell(rstHold) |-> $past(!ctl.step)); // R9
endmodule

// File: rtl/udc_datapath.sv
module udc_datapath
  import udc_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic             clk,
  input  ctl_t             ctl,
  input  logic [WIDTH-1:0] loadVal,
  input  logic             cinN,
  output logic [WIDTH-1:0] countOut,
  output logic             coutN
);
  localparam logic [WIDTH-1:0] TOP  = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] TWO  = WIDTH'(2);

  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] nxtUp;
  logic [WIDTH-1:0] nxtDn;
  logic [WIDTH-1:0] nxt;
  logic             clr;
  logic             atTerm;

  assign clr = ctl.clear;

  generate
    if (DECADE) begin : g_decade
      always_comb begin
        if (cnt == TOP)     nxtUp = ZERO;
        else if (cnt > TOP) nxtUp = cnt[0] ? ZERO : cnt + ONE;
        else                nxtUp = cnt + ONE;
        if (cnt == ZERO)    nxtDn = TOP;
        else if (cnt > TOP) nxtDn = cnt - TWO;
        else                nxtDn = cnt - ONE;
      end
    end else begin : g_binary
      assign nxtUp = cnt + ONE;
      assign nxtDn = cnt - ONE;
    end
  endgenerate

  assign nxt = ctl.dirUp ? nxtUp : nxtDn;

  always_ff @(posedge clk or posedge clr) begin
    if (clr)           cnt <= ZERO;
    else if (ctl.load) cnt <= loadVal;
    else if (ctl.step) cnt <= nxt;
  end

  // While a load is active, the load value bypasses the register so it appears without an edge.
  assign countOut = ctl.load ? loadVal : cnt;
  assign atTerm   = ctl.dirUp ? (countOut == TOP) : (countOut == ZERO);
  assign coutN    = cinN | ~atTerm;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clr)
    (!ctl.step && !ctl.load) |=> $stable(cnt)); // R3
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (clr)
    ctl.load |=> (cnt == $past(loadVal))); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (clr)
    (ctl.step && ctl.dirUp && !ctl.load && cnt < TOP) |=> (cnt == $past(cnt) + ONE)); // R4
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (clr)
    (ctl.step && !ctl.dirUp && !ctl.load && cnt != ZERO && cnt <= TOP) |=> (cnt == $past(cnt) - ONE)); // R4
  AST_STAY_LEGAL: assert property (@(posedge clk) disable iff (clr)
    (ctl.step && !ctl.load && cnt <= TOP) |=> (cnt <= TOP)); // R5
  AST_RECOVER_DOWN: assert property (@(posedge clk) disable iff (clr)
    (ctl.step && !ctl.dirUp && !ctl.load && cnt > TOP) |=> (cnt < $past(cnt))); // R8
  AST_CARRY_AT_END: assert property (@(posedge clk) disable iff (clr)
    !coutN |-> (!cinN && (countOut == ZERO || countOut == TOP))); // R6
endmodule

// File: rtl/ud_count_stage.sv
module ud_count_stage
  import udc_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic             clk,
  input  logic             resetIn,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] loadVal,
  input  logic             cinN,
  input  logic             countUp,
  output logic [WIDTH-1:0] countOut,
  output logic             coutN
);
  ctl_t ctl;

  udc_ctrl u_ctrl (
    .clk     (clk),
    .resetIn (resetIn),
    .loadEn  (loadEn),
    .cinN    (cinN),
    .countUp (countUp),
    .ctl     (ctl)
  );

  udc_datapath #(.WIDTH(WIDTH), .DECADE(DECADE)) u_dp (
    .clk      (clk),
    .ctl      (ctl),
    .loadVal  (loadVal),
    .cinN     (cinN),
    .countOut (countOut),
    .coutN    (coutN)
  );

  AST_ENABLE_GATES_CARRY: assert property (@(posedge clk) disable iff (resetIn)
    cinN |-> coutN); // R7
endmodule

// File: tb/ud_count_stage_tb.sv
module ud_count_stage_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       resetIn = 1'b1, loadEn = 1'b0, cinN = 1'b1, countUp = 1'b1;
  logic [3:0] loadVal = 4'd0;
  int         chainJam = 0;

  logic [3:0] decOut, binOut, d0, d1, d2;
  logic       decCo, binCo, co0, co1, co2;
  logic [3:0] j0, j1, j2;
  assign j0 = 4'(chainJam % 10);
  assign j1 = 4'((chainJam / 10) % 10);
  assign j2 = 4'((chainJam / 100) % 10);

  ud_count_stage #(.WIDTH(4), .DECADE(1'b1)) u_dut (.clk(clk), .resetIn(resetIn), .loadEn(loadEn),
    .loadVal(loadVal), .cinN(cinN), .countUp(countUp), .countOut(decOut), .coutN(decCo));
  ud_count_stage #(.WIDTH(4), .DECADE(1'b0)) u_bin (.clk(clk), .resetIn(resetIn), .loadEn(loadEn),
    .loadVal(loadVal), .cinN(cinN), .countUp(countUp), .countOut(binOut), .coutN(binCo));
  ud_count_stage #(.WIDTH(4), .DECADE(1'b1)) u_c0 (.clk(clk), .resetIn(resetIn), .loadEn(loadEn),
    .loadVal(j0), .cinN(cinN), .countUp(countUp), .countOut(d0), .coutN(co0));
  ud_count_stage #(.WIDTH(4), .DECADE(1'b1)) u_c1 (.clk(clk), .resetIn(resetIn), .loadEn(loadEn),
    .loadVal(j1), .cinN(co0), .countUp(countUp), .countOut(d1), .coutN(co1));
  ud_count_stage #(.WIDTH(4), .DECADE(1'b1)) u_c2 (.clk(clk), .resetIn(resetIn), .loadEn(loadEn),
    .loadVal(j2), .cinN(co1), .countUp(countUp), .countOut(d2), .coutN(co2));

  int total = 0;
  int bad = 0;
  int mDec = 0, mBin = 0, mChain = 0;
  bit mHold = 1'b1;

  task automatic chk(int act, int exp, string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nextDec(int v, bit up);
    if (up) return (v == 9) ? 0 : (v > 9) ? ((v % 2 == 1) ? 0 : v + 1) : v + 1;
    return (v == 0) ? 9 : (v > 9) ? v - 2 : v - 1;
  endfunction

  // One cycle: drive on the falling edge, check before the rising edge, update the model on it.
  task automatic cyc(bit r, bit l, int j, bit c, bit u, int cj, string req);
    int eDec, eBin, eChain;
    @(negedge clk);
    resetIn = r; loadEn = l; loadVal = 4'(j); cinN = c; countUp = u; chainJam = cj;
    #2;
    eDec   = r ? 0 : l ? j : mDec;
    eBin   = r ? 0 : l ? j : mBin;
    eChain = r ? 0 : l ? cj : mChain;
    chk(int'(decOut), eDec, req);
    chk(int'(decCo), (c || !(u ? eDec == 9 : eDec == 0)) ? 1 : 0, {req, " R6 decade carry"});
    chk(int'(binOut), eBin, req);
    chk(int'(binCo), (c || !(u ? eBin == 15 : eBin == 0)) ? 1 : 0, {req, " R6 binary carry"});
    chk(int'(d2) * 100 + int'(d1) * 10 + int'(d0), eChain, {req, " R7 chain"});
    chk(int'(co2), (c || !(u ? eChain == 999 : eChain == 0)) ? 1 : 0, {req, " R7 chain carry"});
    @(posedge clk);
    if (r) begin
      mDec = 0; mBin = 0; mChain = 0; mHold = 1'b1;
    end else begin
      if (l) begin
        mDec = j; mBin = j; mChain = cj;
      end else if (!c && !mHold) begin
        mDec   = nextDec(mDec, u);
        mBin   = u ? (mBin + 1) % 16 : (mBin + 15) % 16;
        mChain = u ? (mChain + 1) % 1000 : (mChain + 999) % 1000;
      end
      mHold = 1'b0;
    end
  endtask

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state, with the other inputs trying to act
    cyc(1, 0, 0, 0, 1, 0, "R1 reset");
    cyc(1, 1, 7, 0, 1, 345, "R1 reset over load");
    // R9: first edge after release does not count
    cyc(0, 0, 0, 0, 1, 0, "R9 release edge");
    cyc(0, 0, 0, 0, 1, 0, "R9 first count");
    // R4, R5: count up through wraps
    for (int i = 0; i < 25; i++) cyc(0, 0, 0, 0, 1, 0, "R4 R5 up");
    // R3: hold with carry input high
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 1, 0, "R3 hold");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 0, 0, "R3 hold down");
    // R4, R5: count down through 0
    for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 0, 0, "R4 R5 down");
    // R2: load overrides counting, then stays after release
    cyc(0, 1, 7, 0, 1, 995, "R2 load");
    cyc(0, 1, 7, 0, 0, 995, "R2 load held");
    cyc(0, 0, 0, 1, 1, 0, "R2 kept");
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 1, 0, "R7 chain up over 999");
    cyc(0, 1, 3, 1, 0, 2, "R2 load mid count");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 0, "R7 chain down over 0");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 0, "R4 direction change");
    // R1: reset raised between edges clears at once
    cyc(1, 0, 0, 0, 1, 0, "R1 async clear");
    cyc(0, 0, 0, 0, 1, 0, "R9 release again");
    cyc(0, 0, 0, 0, 0, 0, "R9 counts after release");
    // R8: recovery from unused codes in both directions
    for (int code = 10; code < 16; code++) begin
      for (int dir = 0; dir < 2; dir++) begin
        int steps = 0;
        int lim = (dir == 1) ? 2 : 4;
        cyc(0, 1, code, 1, dir[0], 0, "R8 load unused");
        for (int k = 1; k <= 6; k++) begin
          cyc(0, 0, 0, 0, dir[0], 0, "R8 recover");
          #1;
          if (steps == 0 && decOut <= 4'd9) steps = k;
        end
        chk((steps >= 1 && steps <= lim) ? 1 : 0, 1, "R8 recovery bound");
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule